// File: doc/BRIEF.md
# Event-Driven Up/Down Timer Counter

This block is a synchronous counter whose value is moved either by free counting in a programmed direction or by two external event lines. Each event line has its own 3-bit action select. The step action lets event line 0 add one and event line 1 subtract one, whatever direction is programmed. The fault action halts the counter and drives preset levels onto the compare channel outputs until the fault is cleared.

The direction is a single bit changed by separate set and clear strobes. When neither event line is set to the step action, the enable alone runs the counter freely. The count wraps between zero and a programmable top value and gives a one-cycle overflow pulse on each wrap. Each compare channel output is high while the count is below that channel's compare value, unless a latched fault forces it.

Top module: `evTimer`

## Requirements
- R1: While reset is low and on the first cycle after it, count is 0, ovf is 0, faultActive is 0, and the direction is up (1 = down).
- R2: When neither event line has the step action (code 4) and the counter is enabled and not frozen, the count moves by one on every clock in the programmed direction.
- R3: A dirSet pulse makes the direction down and a dirClr pulse makes it up, taking effect on the next clock. When both pulse in the same cycle, dirSet wins.
- R4: With act0 = 4, each ev0 pulse adds one to the count whatever the direction. Between events the count holds, and it does not free-run.
- R5: With act1 = 4, each ev1 pulse subtracts one from the count whatever the direction. Between events the count holds.
- R6: When ev0 and ev1 both pulse in one cycle with act0 = 4 and act1 = 4, the count does not change.
- R7: Counting up from a value at or above topVal loads 0, and ovf is high for exactly the cycle after that step.
- R8: Counting down from 0 loads topVal, and ovf is high for exactly the cycle after that step.
- R9: An event on a line whose action is 7 sets faultActive on the next clock. The count does not change on that clock or on any clock while faultActive is high.
- R10: faultActive stays set until a faultClr pulse. A fault event in the same cycle as faultClr keeps it set.
- R11: Bit i of chOut is 1 when the count is below compare value i (bits i*CNT_W upward of cmpVal). While faultActive is high and ovrEn[i] is 1, bit i instead equals ovrVal[i].
- R12: Action codes other than 4 and 7 behave as code 0: the event is ignored. With enable low, the count holds and no ovf is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Counter enable |
| dirSet | input | 1 | Strobe that makes the direction down |
| dirClr | input | 1 | Strobe that makes the direction up |
| ev0 | input | 1 | Event line 0 |
| ev1 | input | 1 | Event line 1 |
| act0 | input | 3 | Action select for event line 0 |
| act1 | input | 3 | Action select for event line 1 |
| faultClr | input | 1 | Clears a latched fault |
| topVal | input | CNT_W | Wrap limit of the count |
| cmpVal | input | CH_N*CNT_W | Packed compare values, one per channel |
| ovrEn | input | CH_N | Per-channel fault override enable |
| ovrVal | input | CH_N | Per-channel forced level during a fault |
| count | output | CNT_W | Current count |
| ovf | output | 1 | One-cycle wrap pulse |
| faultActive | output | 1 | Latched fault flag |
| chOut | output | CH_N | Compare channel outputs |

## Verification
Directed runs first drive free counting in both directions with a small top value. This separates the up-wrap and down-wrap loads from plain stepping and shows which strobe wins when both direction strobes pulse together. Event-only patterns, with the programmed direction set against each event, show whether the step action really overrides the direction, whether the count holds between events, and whether simultaneous opposite events cancel. Fault patterns, with a clear pulse arriving alone and together with a fresh fault, separate freezing from clearing and check the override per channel. Random mixes of action codes, including unlisted ones, then mix all of these with changing top, compare and override inputs.

// File: rtl/evTimerPkg.sv
package evTimerPkg;
  localparam logic [2:0] ACT_OFF   = 3'd0;
  localparam logic [2:0] ACT_STEP  = 3'd4;
  localparam logic [2:0] ACT_FAULT = 3'd7;

  // strobes from control to datapath
  typedef struct packed {
    logic step;  // move the count by one this cycle
    logic down;  // direction of that move
  } ctrlStrobeT;
endpackage

// File: rtl/evTimerCtrl.sv
module evTimerCtrl
  import evTimerPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       dirSet,
  input  logic       dirClr,
  input  logic       ev0,
  input  logic       ev1,
  input  logic [2:0] act0,
  input  logic [2:0] act1,
  input  logic       faultClr,
  output ctrlStrobeT stb,
  output logic       faultActive
);
  logic dirDown;
  logic faultQ;
  logic faultEvt;
  logic incSel;
  logic decSel;
  logic upEv;
  logic dnEv;
  logic freeze;

  // decode the action selects
  always_comb begin
    faultEvt = (ev0 && act0 == ACT_FAULT) || (ev1 && act1 == ACT_FAULT);
    incSel   = (act0 == ACT_STEP);
    decSel   = (act1 == ACT_STEP);
    upEv     = incSel && ev0;
    dnEv     = decSel && ev1;
    freeze   = faultQ || faultEvt;
  end

  // pick the step for the datapath
  always_comb begin
    stb = '0;
    if (!freeze && enable) begin
      if (incSel || decSel) begin
        stb.step = upEv ^ dnEv;
        stb.down = dnEv;
      end else begin
        stb.step = 1'b1;
        stb.down = dirDown;
      end
    end
  end

  // direction bit: set strobe has priority
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        dirDown <= 1'b0;
    else if (dirSet)  dirDown <= 1'b1;
    else if (dirClr)  dirDown <= 1'b0;
  end

  // fault latch: a new fault beats the clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         faultQ <= 1'b0;
    else if (faultEvt) faultQ <= 1'b1;
    else if (faultClr) faultQ <= 1'b0;
  end

  assign faultActive = faultQ;
endmodule

// File: rtl/evTimerPath.sv
module evTimerPath
  import evTimerPkg::*;
#(
  parameter int CNT_W = 8,
  parameter int CH_N  = 2
)(
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrlStrobeT            stb,
  input  logic [CNT_W-1:0]      topVal,
  input  logic [CH_N*CNT_W-1:0] cmpVal,
  input  logic [CH_N-1:0]       ovrEn,
  input  logic [CH_N-1:0]       ovrVal,
  input  logic                  faultActive,
  output logic [CNT_W-1:0]      count,
  output logic                  ovf,
  output logic [CH_N-1:0]       chOut
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] countQ;
  logic [CNT_W-1:0] nextCount;
  logic             atWrap;
  logic             ovfQ;

  always_comb begin
    if (stb.down) begin
      atWrap    = (countQ == '0);
      nextCount = atWrap ? topVal : countQ - ONE;
    end else begin
      atWrap    = (countQ >= topVal);
      nextCount = atWrap ? '0 : countQ + ONE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countQ <= '0;
      ovfQ   <= 1'b0;
    end else if (stb.step) begin
      countQ <= nextCount;
      ovfQ   <= atWrap;
    end else begin
      ovfQ   <= 1'b0;
    end
  end

  for (genvar i = 0; i < CH_N; i++) begin : gCh
    logic [CNT_W-1:0] cmpI;
    assign cmpI     = cmpVal[i*CNT_W +: CNT_W];
    assign chOut[i] = (faultActive && ovrEn[i]) ? ovrVal[i] : (countQ < cmpI);
  end

  assign count = countQ;
  assign ovf   = ovfQ;
endmodule

// File: rtl/evTimer.sv
module evTimer
  import evTimerPkg::*;
#(
  parameter int CNT_W = 8,
  parameter int CH_N  = 2
)(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  enable,
  input  logic                  dirSet,
  input  logic                  dirClr,
  input  logic                  ev0,
  input  logic                  ev1,
  input  logic [2:0]            act0,
  input  logic [2:0]            act1,
  input  logic                  faultClr,
  input  logic [CNT_W-1:0]      topVal,
  input  logic [CH_N*CNT_W-1:0] cmpVal,
  input  logic [CH_N-1:0]       ovrEn,
  input  logic [CH_N-1:0]       ovrVal,
  output logic [CNT_W-1:0]      count,
  output logic                  ovf,
  output logic                  faultActive,
  output logic [CH_N-1:0]       chOut
);
  ctrlStrobeT stb;

  evTimerCtrl uCtrl (
    .clk(clk), .rstN(rstN), .enable(enable), .dirSet(dirSet), .dirClr(dirClr),
    .ev0(ev0), .ev1(ev1), .act0(act0), .act1(act1), .faultClr(faultClr),
    .stb(stb), .faultActive(faultActive)
  );

  evTimerPath #(.CNT_W(CNT_W), .CH_N(CH_N)) uPath (
    .clk(clk), .rstN(rstN), .stb(stb), .topVal(topVal), .cmpVal(cmpVal),
    .ovrEn(ovrEn), .ovrVal(ovrVal), .faultActive(faultActive),
    .count(count), .ovf(ovf), .chOut(chOut)
  );
endmodule

// File: rtl/evTimerChk.sv
module evTimerChk
  import evTimerPkg::*;
#(
  parameter int CNT_W = 8,
  parameter int CH_N  = 2
)(
  input logic                  clk,
  input logic                  rstN,
  input logic                  enable,
  input logic                  ev0,
  input logic                  ev1,
  input logic [2:0]            act0,
  input logic [2:0]            act1,
  input logic [CNT_W-1:0]      topVal,
  input logic [CH_N-1:0]       ovrEn,
  input logic [CH_N-1:0]       ovrVal,
  input logic [CNT_W-1:0]      count,
  input logic                  ovf,
  input logic                  faultActive,
  input logic [CH_N-1:0]       chOut
);
  logic faultEvt;
  assign faultEvt = (ev0 && act0 == ACT_FAULT) || (ev1 && act1 == ACT_FAULT);

  assert_enable_hold_R12: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> ($stable(count) && !ovf));

  assert_both_cancel_R6: assert property (@(posedge clk) disable iff (!rstN)
    (act0 == ACT_STEP && act1 == ACT_STEP && ev0 && ev1) |=> $stable(count));

  assert_fault_latch_R9: assert property (@(posedge clk) disable iff (!rstN)
    faultEvt |=> faultActive);

  assert_fault_freeze_R9: assert property (@(posedge clk) disable iff (!rstN)
    (faultActive || faultEvt) |=> ($stable(count) && !ovf));

  assert_ovf_value_R7: assert property (@(posedge clk) disable iff (!rstN)
    ovf |-> (count == '0 || count == $past(topVal)));

  for (genvar i = 0; i < CH_N; i++) begin : gOvr
    assert_override_R11: assert property (@(posedge clk) disable iff (!rstN)
      (faultActive && ovrEn[i]) |-> (chOut[i] == ovrVal[i]));
  end
endmodule

bind evTimer evTimerChk #(.CNT_W(CNT_W), .CH_N(CH_N)) uChk (.*);

// File: tb/evTimer_test.sv
module evTimer_test;
  localparam int CNT_W = 8;
  localparam int CH_N  = 2;

  logic                  clk = 1'b0;
  logic                  rstN = 1'b0;
  logic                  enable = 1'b0, dirSet = 1'b0, dirClr = 1'b0;
  logic                  ev0 = 1'b0, ev1 = 1'b0, faultClr = 1'b0;
  logic [2:0]            act0 = 3'd0, act1 = 3'd0;
  logic [CNT_W-1:0]      topVal = 8'd5;
  logic [CH_N*CNT_W-1:0] cmpVal = {8'd4, 8'd2};
  logic [CH_N-1:0]       ovrEn = 2'b00, ovrVal = 2'b00;
  logic [CNT_W-1:0]      count;
  logic                  ovf, faultActive;
  logic [CH_N-1:0]       chOut;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  // model state
  logic [CNT_W-1:0] mCount = '0;
  logic             mDir = 1'b0;
  logic             mFault = 1'b0;
  logic             mOvf = 1'b0;

  evTimer #(.CNT_W(CNT_W), .CH_N(CH_N)) uut (.*);

  always #4 clk = ~clk;

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        bad++;
        total++;
        $display("FAIL watchdog: run hung, actual=%0d cycles expected<150000", cyc);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  function automatic logic [CH_N-1:0] expCh(logic [CNT_W-1:0] c, logic f);
    logic [CH_N-1:0] r;
    for (int i = 0; i < CH_N; i++)
      r[i] = (f && ovrEn[i]) ? ovrVal[i] : (c < cmpVal[i*CNT_W +: CNT_W]);
    return r;
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // one clock: compute model from inputs set by caller, then compare
  task automatic tick(string tag);
    logic fEvt, inc, dec, step, down, wrap;
    logic [CNT_W-1:0] nc;
    fEvt = (ev0 && act0 == 3'd7) || (ev1 && act1 == 3'd7);
    inc = (act0 == 3'd4);
    dec = (act1 == 3'd4);
    step = 1'b0; down = 1'b0;
    if (!(mFault || fEvt) && enable) begin
      if (inc || dec) begin
        step = (inc && ev0) ^ (dec && ev1);
        down = dec && ev1;
      end else begin
        step = 1'b1;
        down = mDir;
      end
    end
    nc = mCount; wrap = 1'b0;
    if (step) begin
      if (down) begin wrap = (mCount == 0); nc = wrap ? topVal : mCount - 1; end
      else begin wrap = (mCount >= topVal); nc = wrap ? '0 : mCount + 1; end
    end
    mCount = nc;
    mOvf = step && wrap;
    mDir = dirSet ? 1'b1 : (dirClr ? 1'b0 : mDir);
    mFault = fEvt ? 1'b1 : (faultClr ? 1'b0 : mFault);
    @(posedge clk);
    #1;
    chk(tag, "count", int'(count), int'(mCount));
    chk(tag, "ovf", int'(ovf), int'(mOvf));
    chk(tag, "faultActive", int'(faultActive), int'(mFault));
    chk(tag, "chOut", int'(chOut), int'(expCh(mCount, mFault)));
    @(negedge clk);
    dirSet = 1'b0; dirClr = 1'b0; ev0 = 1'b0; ev1 = 1'b0; faultClr = 1'b0;
  endtask

  initial begin
    int seedSink;
    seedSink = $urandom(32'd20240611);
    // R1: reset state
    #3;
    chk("R1", "count", int'(count), 0);
    chk("R1", "ovf", int'(ovf), 0);
    chk("R1", "faultActive", int'(faultActive), 0);
    @(negedge clk); @(negedge clk);
    rstN = 1'b1;
    #1;
    chk("R1", "chOut", int'(chOut), int'(expCh('0, 1'b0)));

    // R2 / R7: free run up with top 5, includes wrap
    @(negedge clk);
    enable = 1'b1;
    for (int i = 0; i < 8; i++) tick("R7");
    // R3: both strobes, set wins -> down; R8 down wrap
    dirSet = 1'b1; dirClr = 1'b1; tick("R3");
    for (int i = 0; i < 8; i++) tick("R8");
    dirClr = 1'b1; tick("R3");
    for (int i = 0; i < 3; i++) tick("R2");
    // R12: enable low holds
    enable = 1'b0;
    for (int i = 0; i < 3; i++) tick("R12");
    enable = 1'b1;
    // R12: unlisted codes act as off
    act0 = 3'd3; act1 = 3'd5; ev0 = 1'b1; ev1 = 1'b1; tick("R12");
    tick("R12");
    // R4: increment events against down direction, holds between
    dirSet = 1'b1; tick("R3");
    act0 = 3'd4; act1 = 3'd0;
    for (int i = 0; i < 6; i++) begin ev0 = (i % 2 == 0); tick("R4"); end
    // R5: decrement events while direction is up
    dirClr = 1'b1; act0 = 3'd0; act1 = 3'd4; tick("R5");
    for (int i = 0; i < 8; i++) begin ev1 = 1'b1; tick("R5"); end
    // R6: both at once cancel
    act0 = 3'd4; act1 = 3'd4; ev0 = 1'b1; ev1 = 1'b1; tick("R6");
    ev0 = 1'b1; ev1 = 1'b1; tick("R6");
    // R9 / R11: fault on line 1 with overrides
    act0 = 3'd0; act1 = 3'd7; ovrEn = 2'b01; ovrVal = 2'b01;
    ev1 = 1'b1; tick("R9");
    for (int i = 0; i < 3; i++) tick("R11");
    // R10: clear together with new fault on line 0 stays set, then clear alone
    act0 = 3'd7; ev0 = 1'b1; faultClr = 1'b1; tick("R10");
    tick("R10");
    act0 = 3'd0; act1 = 3'd0; faultClr = 1'b1; tick("R10");
    for (int i = 0; i < 3; i++) tick("R2");

    // random mix
    for (int n = 0; n < 4000; n++) begin
      int pick;
      pick = $urandom_range(0, 9);
      act0 = (pick < 3) ? 3'd0 : (pick < 7) ? 3'd4 : (pick < 8) ? 3'd2 : (pick == 8 && $urandom_range(0, 7) == 0) ? 3'd7 : 3'd0;
      pick = $urandom_range(0, 9);
      act1 = (pick < 3) ? 3'd0 : (pick < 7) ? 3'd4 : (pick < 8) ? 3'd6 : (pick == 8 && $urandom_range(0, 7) == 0) ? 3'd7 : 3'd1;
      ev0 = $urandom_range(0, 1) == 1;
      ev1 = $urandom_range(0, 1) == 1;
      enable = $urandom_range(0, 9) != 0;
      dirSet = $urandom_range(0, 9) == 0;
      dirClr = $urandom_range(0, 9) == 0;
      faultClr = $urandom_range(0, 4) == 0;
      if ($urandom_range(0, 49) == 0) topVal = CNT_W'($urandom_range(0, 20));
      if ($urandom_range(0, 49) == 0) cmpVal = (CH_N*CNT_W)'($urandom);
      ovrEn = CH_N'($urandom);
      ovrVal = CH_N'($urandom);
      tick("R2");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule